// File: doc/BRIEF.md
# Execution Context Privilege Controller

This block sits beside a small RISC-V core and works out which privilege context the core is in by watching its bus. Nothing has to be written by software to change the context. The core boots in firmware context. The first instruction fetched from an address outside the firmware ROM moves the block to application context. Two syscall interrupt levels, low and high, each give a context of their own. The core enters one of them when it takes that interrupt, and it comes back to application context when it returns from the interrupt.

The block uses the current context to grant or refuse three protected areas: the firmware RAM, instruction fetch from the ROM, and a window of secret assets. The assets close for good when the core first leaves firmware context. They stay closed through every later syscall. A refused read gives the core zero data, and a refused write never reaches memory. Both raise a trap one cycle later. Software raises a syscall interrupt by writing to one of two trigger addresses. This sets a pending bit that stays set until the core acknowledges it.

Top module: `exec_priv_ctrl`

## Requirements
- R1: After reset the context is firmware (`ctx` = 2'b00). The asset lock, both pending bits, `irq_req` and `trap` are all zero.
- R2: In firmware context, a fetch (`if_valid`) from an address outside the ROM window moves `ctx` to application (2'b01) on the next clock. A fetch inside the ROM leaves the context in firmware. Once the context has left firmware, it never returns to firmware.
- R3: `asset_lock` sets on the same clock as the move from firmware to application, and it stays set until reset. `asset_en` is high only in firmware context while the lock is clear. A data read of the asset window while `asset_en` is low returns zero on `cpu_rdata`. A data write to the window in that state leaves `mem_we` low.
- R4: `fwram_en` is high only in firmware context or in the high syscall context (2'b11). A refused data read of the firmware RAM returns zero. A refused data write leaves `mem_we` low.
- R5: `rom_exec_en` is high in the firmware, low syscall (2'b10) and high syscall contexts. It is low in application context. A refused ROM fetch returns zero on `cpu_rdata`.
- R6: Each refused access makes `trap` high for exactly the one cycle after it.
- R7: A data write to trigger address `TRIG_BASE + 4*i` sets pending bit i, where bit 0 is the low syscall and bit 1 the high syscall. The bit stays set until that interrupt is taken.
- R8: `irq_req` carries at most one bit, and only in application context. It points at the high source when that source is pending, and otherwise at the low source when that one is pending.
- R9: An `irq_ack` bit that matches `irq_req` takes the interrupt. It clears that pending bit and moves `ctx` to 2'b10 for the low source or 2'b11 for the high source. An ack that does not match is ignored. `irq_ret` in a syscall context moves `ctx` back to 2'b01.
- R10: A write to a trigger address never asserts `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Instruction fetch in progress |
| if_addr | input | ADDR_W | Fetch address |
| da_valid | input | 1 | Data access in progress |
| da_write | input | 1 | Data access is a write |
| da_addr | input | ADDR_W | Data access address |
| irq_ack | input | 2 | Core takes interrupt (bit 0 low, bit 1 high) |
| irq_ret | input | 1 | Core returns from interrupt |
| mem_rdata | input | DATA_W | Read data from the memory system |
| cpu_rdata | output | DATA_W | Read data to the core, zero when refused |
| mem_we | output | 1 | Qualified write enable to memory |
| ctx | output | 2 | Current execution context |
| sys_mode | output | 1 | High while in application context |
| asset_lock | output | 1 | Sticky asset lock |
| fwram_en | output | 1 | Firmware RAM access granted |
| rom_exec_en | output | 1 | ROM fetch granted |
| asset_en | output | 1 | Asset access granted |
| irq_pend | output | 2 | Pending syscall interrupts |
| irq_req | output | 2 | Prioritised interrupt request to the core |
| trap | output | 1 | Illegal-access pulse |

## Verification
The assertions check the context-only properties on every cycle. These are: the lock is sticky and shuts the assets, firmware RAM and ROM are never granted in a context that forbids them, trigger writes never reach memory, the context never falls back to firmware, pending bits hold until taken, and the request is one-hot with the high source first. The bench scenarios show the parts that need a sequence of accesses. These are: the exact clock on which a fetch outside the ROM locks the assets, that refused reads come back as zero and refused writes are dropped in each context, the one-cycle trap after each refusal, and full syscall round trips that enter and leave each level.

// File: rtl/exec_priv_pkg.sv
package exec_priv_pkg;

    typedef enum logic [1:0] {
        CTX_FW     = 2'b00,
        CTX_APP    = 2'b01,
        CTX_SYS_LO = 2'b10,
        CTX_SYS_HI = 2'b11
    } ctx_e;

    typedef struct packed {
        ctx_e ctx;
        logic lock;
    } ctx_state_t;

    localparam int IRQ_LO  = 0;
    localparam int IRQ_HI  = 1;
    localparam int NUM_IRQ = 2;

endpackage

// File: rtl/exec_ctx_fsm.sv
module exec_ctx_fsm
    import exec_priv_pkg::*;
#(
    parameter int NUM_SRC = NUM_IRQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_off_rom,
    input  logic [NUM_SRC-1:0] irq_take,
    input  logic               irq_ret,
    output ctx_e               ctx,
    output logic               lock
);

    ctx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ctx)
            CTX_FW: begin
                if (fetch_off_rom) begin
                    st_d.ctx  = CTX_APP;
                    st_d.lock = 1'b1;
                end
            end
            CTX_APP: begin
                if (irq_take[IRQ_HI])      st_d.ctx = CTX_SYS_HI;
                else if (irq_take[IRQ_LO]) st_d.ctx = CTX_SYS_LO;
            end
            CTX_SYS_LO, CTX_SYS_HI: begin
                if (irq_ret) st_d.ctx = CTX_APP;
            end
            default: st_d.ctx = CTX_FW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ctx: CTX_FW, lock: 1'b0};
        else        st_q <= st_d;
    end

    assign ctx  = st_q.ctx;
    assign lock = st_q.lock;

endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] trig,
    input  logic [NUM_SRC-1:0] irq_ack,
    input  logic               in_app,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] take
);

    logic [NUM_SRC-1:0] pend_d, pend_q;

    // highest index has priority
    always_comb begin
        req = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_q[i] && in_app) req = NUM_SRC'(1) << i;
        end
    end

    assign take = irq_ack & req;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            always_comb begin
                pend_d[g] = pend_q[g];
                if (take[g]) pend_d[g] = 1'b0;
                if (trig[g]) pend_d[g] = 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

endmodule

// File: rtl/access_gate.sv
module access_gate
    import exec_priv_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                NUM_SRC     = NUM_IRQ,
    parameter logic [ADDR_W-1:0] ROM_BASE    = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] ROM_SIZE    = 32'h0000_2000,
    parameter logic [ADDR_W-1:0] FWRAM_BASE  = 32'hD000_0000,
    parameter logic [ADDR_W-1:0] FWRAM_SIZE  = 32'h0000_0800,
    parameter logic [ADDR_W-1:0] ASSET_BASE  = 32'hB000_0000,
    parameter logic [ADDR_W-1:0] ASSET_SIZE  = 32'h0000_0100,
    parameter logic [ADDR_W-1:0] TRIG_BASE   = 32'hE000_0000,
    parameter int                TRIG_STRIDE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctx_e               ctx,
    input  logic               lock,
    input  logic               if_valid,
    input  logic [ADDR_W-1:0]  if_addr,
    input  logic               da_valid,
    input  logic               da_write,
    input  logic [ADDR_W-1:0]  da_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               mem_we,
    output logic               fwram_en,
    output logic               rom_exec_en,
    output logic               asset_en,
    output logic               fetch_off_rom,
    output logic [NUM_SRC-1:0] trig,
    output logic               trap
);

    function automatic logic hit(input logic [ADDR_W-1:0] a,
                                 input logic [ADDR_W-1:0] base,
                                 input logic [ADDR_W-1:0] size);
        return (a >= base) && ((a - base) < size);
    endfunction

    logic if_in_rom, da_in_fwram, da_in_asset;
    logic fetch_deny, data_deny, any_deny, trig_hit;
    logic trap_d, trap_q;

    assign if_in_rom   = hit(if_addr, ROM_BASE, ROM_SIZE);
    assign da_in_fwram = hit(da_addr, FWRAM_BASE, FWRAM_SIZE);
    assign da_in_asset = hit(da_addr, ASSET_BASE, ASSET_SIZE);

    assign fwram_en    = (ctx == CTX_FW) || (ctx == CTX_SYS_HI);
    assign rom_exec_en = (ctx != CTX_APP);
    assign asset_en    = (ctx == CTX_FW) && !lock;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_trig
            localparam logic [ADDR_W-1:0] TADDR =
                TRIG_BASE + ADDR_W'(g * TRIG_STRIDE);
            assign trig[g] = da_valid && da_write && (da_addr == TADDR);
        end
    endgenerate

    assign trig_hit      = |trig;
    assign fetch_off_rom = if_valid && !if_in_rom;
    assign fetch_deny    = if_valid && if_in_rom && !rom_exec_en;
    assign data_deny     = da_valid && ((da_in_fwram && !fwram_en) ||
                                        (da_in_asset && !asset_en));
    assign any_deny      = fetch_deny || data_deny;

    assign cpu_rdata = any_deny ? '0 : mem_rdata;
    assign mem_we    = da_valid && da_write && !data_deny && !trig_hit;

    always_comb begin
        trap_d = any_deny;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= trap_d;
    end

    assign trap = trap_q;

endmodule

// File: rtl/exec_priv_ctrl.sv
module exec_priv_ctrl
    import exec_priv_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] ROM_BASE    = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] ROM_SIZE    = 32'h0000_2000,
    parameter logic [ADDR_W-1:0] FWRAM_BASE  = 32'hD000_0000,
    parameter logic [ADDR_W-1:0] FWRAM_SIZE  = 32'h0000_0800,
    parameter logic [ADDR_W-1:0] ASSET_BASE  = 32'hB000_0000,
    parameter logic [ADDR_W-1:0] ASSET_SIZE  = 32'h0000_0100,
    parameter logic [ADDR_W-1:0] TRIG_BASE   = 32'hE000_0000,
    parameter int                TRIG_STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_valid,
    input  logic [ADDR_W-1:0] if_addr,
    input  logic              da_valid,
    input  logic              da_write,
    input  logic [ADDR_W-1:0] da_addr,
    input  logic [1:0]        irq_ack,
    input  logic              irq_ret,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_we,
    output logic [1:0]        ctx,
    output logic              sys_mode,
    output logic              asset_lock,
    output logic              fwram_en,
    output logic              rom_exec_en,
    output logic              asset_en,
    output logic [1:0]        irq_pend,
    output logic [1:0]        irq_req,
    output logic              trap
);

    ctx_e               ctx_w;
    logic               lock_w;
    logic               fetch_off_rom;
    logic [NUM_IRQ-1:0] trig, take;

    exec_ctx_fsm #(.NUM_SRC(NUM_IRQ)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_off_rom (fetch_off_rom),
        .irq_take      (take),
        .irq_ret       (irq_ret),
        .ctx           (ctx_w),
        .lock          (lock_w)
    );

    irq_pend_unit #(.NUM_SRC(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .irq_ack (irq_ack),
        .in_app  (ctx_w == CTX_APP),
        .pend    (irq_pend),
        .req     (irq_req),
        .take    (take)
    );

    access_gate #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .NUM_SRC     (NUM_IRQ),
        .ROM_BASE    (ROM_BASE),
        .ROM_SIZE    (ROM_SIZE),
        .FWRAM_BASE  (FWRAM_BASE),
        .FWRAM_SIZE  (FWRAM_SIZE),
        .ASSET_BASE  (ASSET_BASE),
        .ASSET_SIZE  (ASSET_SIZE),
        .TRIG_BASE   (TRIG_BASE),
        .TRIG_STRIDE (TRIG_STRIDE)
    ) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctx           (ctx_w),
        .lock          (lock_w),
        .if_valid      (if_valid),
        .if_addr       (if_addr),
        .da_valid      (da_valid),
        .da_write      (da_write),
        .da_addr       (da_addr),
        .mem_rdata     (mem_rdata),
        .cpu_rdata     (cpu_rdata),
        .mem_we        (mem_we),
        .fwram_en      (fwram_en),
        .rom_exec_en   (rom_exec_en),
        .asset_en      (asset_en),
        .fetch_off_rom (fetch_off_rom),
        .trig          (trig),
        .trap          (trap)
    );

    assign ctx        = ctx_w;
    assign sys_mode   = (ctx_w == CTX_APP);
    assign asset_lock = lock_w;

endmodule

// File: rtl/exec_priv_ctrl_chk.sv
module exec_priv_ctrl_chk #(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] ASSET_BASE  = 32'hB000_0000,
    parameter logic [ADDR_W-1:0] ASSET_SIZE  = 32'h0000_0100,
    parameter logic [ADDR_W-1:0] TRIG_BASE   = 32'hE000_0000,
    parameter int                TRIG_STRIDE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              da_valid,
    input logic              da_write,
    input logic [ADDR_W-1:0] da_addr,
    input logic [1:0]        irq_ack,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              mem_we,
    input logic [1:0]        ctx,
    input logic              asset_lock,
    input logic              fwram_en,
    input logic              rom_exec_en,
    input logic              asset_en,
    input logic [1:0]        irq_pend,
    input logic [1:0]        irq_req
);

    localparam logic [ADDR_W-1:0] TRIG_HI_ADDR = TRIG_BASE + ADDR_W'(TRIG_STRIDE);

    logic rd_asset;
    assign rd_asset = da_valid && !da_write && (da_addr >= ASSET_BASE) &&
                      ((da_addr - ASSET_BASE) < ASSET_SIZE);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        asset_lock |=> asset_lock); // R3
    AST_LOCK_SHUTS_ASSETS: assert property (@(posedge clk) disable iff (!rst_n)
        asset_lock |-> !asset_en); // R3
    AST_ASSET_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_asset && !asset_en) |-> (cpu_rdata == '0)); // R3
    AST_NO_FW_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx != 2'b00) |=> (ctx != 2'b00)); // R2
    AST_FWRAM_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        fwram_en |-> (ctx == 2'b00 || ctx == 2'b11)); // R4
    AST_ROM_APP_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx == 2'b01) |-> !rom_exec_en); // R5
    AST_PEND_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend[0] && !irq_ack[0]) |=> irq_pend[0]); // R7
    AST_PEND_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend[1] && !irq_ack[1]) |=> irq_pend[1]); // R7
    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_req)); // R8
    AST_REQ_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend[1] && ctx == 2'b01) |-> (irq_req == 2'b10)); // R8
    AST_REQ_APP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx != 2'b01) |-> (irq_req == 2'b00)); // R8
    AST_TRIG_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && da_write && (da_addr == TRIG_BASE || da_addr == TRIG_HI_ADDR))
        |-> !mem_we); // R10

endmodule

bind exec_priv_ctrl exec_priv_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .ASSET_BASE  (ASSET_BASE),
    .ASSET_SIZE  (ASSET_SIZE),
    .TRIG_BASE   (TRIG_BASE),
    .TRIG_STRIDE (TRIG_STRIDE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .da_valid    (da_valid),
    .da_write    (da_write),
    .da_addr     (da_addr),
    .irq_ack     (irq_ack),
    .cpu_rdata   (cpu_rdata),
    .mem_we      (mem_we),
    .ctx         (ctx),
    .asset_lock  (asset_lock),
    .fwram_en    (fwram_en),
    .rom_exec_en (rom_exec_en),
    .asset_en    (asset_en),
    .irq_pend    (irq_pend),
    .irq_req     (irq_req)
);

// File: tb/exec_priv_ctrl_bench.sv
module exec_priv_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RDATA   = 32'hA5A5_1234;
    localparam logic [31:0] A_ROM   = 32'h0000_0100;
    localparam logic [31:0] A_APP   = 32'h4000_0000;
    localparam logic [31:0] A_FWRAM = 32'hD000_0004;
    localparam logic [31:0] A_ASSET = 32'hB000_0010;
    localparam logic [31:0] A_TLO   = 32'hE000_0000;
    localparam logic [31:0] A_THI   = 32'hE000_0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_valid = 1'b0, da_valid = 1'b0, da_write = 1'b0, irq_ret = 1'b0;
    logic [31:0] if_addr = '0, da_addr = '0;
    logic [1:0]  irq_ack = '0;
    logic [31:0] mem_rdata = RDATA;
    logic [31:0] cpu_rdata;
    logic        mem_we, sys_mode, asset_lock, fwram_en, rom_exec_en, asset_en, trap;
    logic [1:0]  ctx, irq_pend, irq_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_priv_ctrl u_exec_priv_ctrl (
        .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_addr(if_addr),
        .da_valid(da_valid), .da_write(da_write), .da_addr(da_addr),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .mem_rdata(mem_rdata),
        .cpu_rdata(cpu_rdata), .mem_we(mem_we), .ctx(ctx), .sys_mode(sys_mode),
        .asset_lock(asset_lock), .fwram_en(fwram_en), .rom_exec_en(rom_exec_en),
        .asset_en(asset_en), .irq_pend(irq_pend), .irq_req(irq_req), .trap(trap)
    );

    typedef struct {
        string       tag;
        string       name;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t sb_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    event  chk_ev;

    // reference model state
    logic [1:0] m_ctx = 2'b00;
    logic       m_lock = 1'b0;
    logic [1:0] m_pend = 2'b00;
    logic       m_trap = 1'b0;

    function automatic logic [31:0] actual(int sel);
        case (sel)
            0: return {30'd0, ctx};
            1: return {31'd0, asset_lock};
            2: return {30'd0, irq_pend};
            3: return {30'd0, irq_req};
            4: return {31'd0, fwram_en};
            5: return {31'd0, rom_exec_en};
            6: return {31'd0, asset_en};
            7: return {31'd0, trap};
            8: return cpu_rdata;
            9: return {31'd0, mem_we};
            default: return {31'd0, sys_mode};
        endcase
    endfunction

    // monitor: pops expected items and compares with the design
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = actual(it.sel);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s %s: actual %h expected %h", it.tag, it.name, act, it.exp);
                end
            end
        end
    end

    function automatic void push(string tag, string name, int sel, logic [31:0] exp);
        item_t it;
        it.tag = tag; it.name = name; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
    endfunction

    function automatic logic in_win(logic [31:0] a, logic [31:0] b, logic [31:0] s);
        return (a >= b) && ((a - b) < s);
    endfunction

    task automatic step(string tag, logic ifv, logic [31:0] ifa,
                        logic dv, logic dw, logic [31:0] da,
                        logic [1:0] ack, logic ret);
        logic fw_ok, rom_ok, as_ok, deny, in_rom;
        logic [1:0] req, take;
        @(negedge clk);
        if_valid = ifv; if_addr = ifa; da_valid = dv; da_write = dw; da_addr = da;
        irq_ack = ack; irq_ret = ret;
        #1;
        fw_ok  = (m_ctx == 2'b00) || (m_ctx == 2'b11);
        rom_ok = (m_ctx != 2'b01);
        as_ok  = (m_ctx == 2'b00) && !m_lock;
        in_rom = in_win(ifa, 32'h0, 32'h2000);
        req    = (m_ctx != 2'b01) ? 2'b00 : m_pend[1] ? 2'b10 : m_pend[0] ? 2'b01 : 2'b00;
        take   = ack & req;
        deny   = (ifv && in_rom && !rom_ok) ||
                 (dv && ((in_win(da, 32'hD000_0000, 32'h800) && !fw_ok) ||
                         (in_win(da, 32'hB000_0000, 32'h100) && !as_ok)));
        push(tag, "ctx",         0, {30'd0, m_ctx});
        push(tag, "asset_lock",  1, {31'd0, m_lock});
        push(tag, "irq_pend",    2, {30'd0, m_pend});
        push(tag, "irq_req",     3, {30'd0, req});
        push(tag, "fwram_en",    4, {31'd0, fw_ok});
        push(tag, "rom_exec_en", 5, {31'd0, rom_ok});
        push(tag, "asset_en",    6, {31'd0, as_ok});
        push(tag, "trap",        7, {31'd0, m_trap});
        push(tag, "cpu_rdata",   8, deny ? 32'h0 : RDATA);
        push(tag, "mem_we",      9, {31'd0, dv && dw && !deny && da != A_TLO && da != A_THI});
        push(tag, "sys_mode",   10, {31'd0, m_ctx == 2'b01});
        ->chk_ev;
        #1;
        // advance model to the state after the coming clock edge
        m_trap = deny;
        m_pend = (m_pend & ~take) |
                 {dv && dw && da == A_THI, dv && dw && da == A_TLO};
        case (m_ctx)
            2'b00: if (ifv && !in_rom) begin m_ctx = 2'b01; m_lock = 1'b1; end
            2'b01: if (take[1]) m_ctx = 2'b11; else if (take[0]) m_ctx = 2'b10;
            default: if (ret) m_ctx = 2'b01;
        endcase
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, '0, 1'b0, 1'b0, '0, 2'b00, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle("R1");                                              // reset state
        step("R5", 1'b1, A_ROM,   1'b0, 1'b0, '0,      2'b00, 1'b0); // ROM fetch in fw
        step("R3", 1'b0, '0,      1'b1, 1'b0, A_ASSET, 2'b00, 1'b0); // asset read ok
        step("R4", 1'b0, '0,      1'b1, 1'b1, A_FWRAM, 2'b00, 1'b0); // fwram write ok
        step("R10", 1'b1, A_ROM,  1'b1, 1'b1, A_TLO,   2'b00, 1'b0); // trigger low
        step("R8", 1'b1, A_ROM,   1'b0, 1'b0, '0,      2'b01, 1'b0); // no req in fw, ack ignored
        step("R7", 1'b1, A_ROM,   1'b0, 1'b0, '0,      2'b00, 1'b0); // pending held
        step("R2", 1'b1, A_APP,   1'b0, 1'b0, '0,      2'b00, 1'b0); // leave fw
        step("R3", 1'b1, A_APP,   1'b1, 1'b0, A_ASSET, 2'b00, 1'b0); // locked, read zero
        step("R6", 1'b1, A_APP,   1'b1, 1'b1, A_ASSET, 2'b00, 1'b0); // trap, write dropped
        step("R6", 1'b1, A_APP,   1'b0, 1'b0, '0,      2'b00, 1'b0);
        idle("R6");                                              // trap gone
        step("R5", 1'b1, A_ROM,   1'b0, 1'b0, '0,      2'b00, 1'b0); // ROM fetch denied
        step("R4", 1'b0, '0,      1'b1, 1'b1, A_FWRAM, 2'b00, 1'b0); // fwram write denied
        step("R4", 1'b0, '0,      1'b1, 1'b0, A_FWRAM, 2'b00, 1'b0); // fwram read zero
        step("R8", 1'b0, '0,      1'b1, 1'b1, A_THI,   2'b00, 1'b0); // trigger high
        step("R9", 1'b0, '0,      1'b0, 1'b0, '0,      2'b01, 1'b0); // mismatched ack
        step("R9", 1'b0, '0,      1'b0, 1'b0, '0,      2'b10, 1'b0); // take high
        step("R4", 1'b1, A_ROM,   1'b1, 1'b0, A_FWRAM, 2'b00, 1'b0); // sys_hi grants
        step("R3", 1'b0, '0,      1'b1, 1'b0, A_ASSET, 2'b00, 1'b0); // still locked
        step("R9", 1'b0, '0,      1'b0, 1'b0, '0,      2'b00, 1'b1); // return
        step("R9", 1'b0, '0,      1'b0, 1'b0, '0,      2'b01, 1'b0); // take low
        step("R5", 1'b1, A_ROM,   1'b1, 1'b0, A_FWRAM, 2'b00, 1'b0); // sys_lo: rom ok, fwram no
        step("R9", 1'b0, '0,      1'b0, 1'b0, '0,      2'b00, 1'b1); // return
        step("R7", 1'b0, '0,      1'b1, 1'b1, A_TLO,   2'b00, 1'b0); // retrigger
        step("R2", 1'b1, A_ROM,   1'b0, 1'b0, '0,      2'b00, 1'b0); // stays app
        idle("R3");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule